// File: doc/BRIEF.md
# SPI Timekeeper Register Slave

This block is the serial register face of a small real-time clock. A master on a four-wire SPI link raises chip enable and sends an address byte. The top bit of that byte selects a write or a read, and the low nibble gives the register where a burst starts. Every byte after that moves one register, and the register pointer steps forward after each byte. Time-of-day registers use packed BCD. A control register carries a write-protect flag that blocks updates to the time registers.

A one-second strobe from the surrounding logic advances seconds, minutes and hours, in either 24-hour or 12-hour form. The weekday, day of month, month and two-digit year registers change only when the master writes them. A strobe that arrives while chip enable is high is held back until the frame closes. A burst read therefore always returns one coherent snapshot of the time.

Top module: `rtc_spi_regs`

## Requirements
- R1: A frame starts when chip enable rises and ends when it falls. The first byte is the address: bit 7 set means write, bits 3:0 give the starting register. Bits move MSB first. MOSI is captured on each falling SCK edge. MISO changes only after a falling SCK edge, so it is stable while SCK is high.
- R2: A read burst from address 0x00 returns, in order: seconds, minutes, hours, weekday, day of month, month, year (register indices 0 to 6).
- R3: A write burst from address 0x80 fills the same seven registers in the same order.
- R4: The pointer steps after every data byte. It wraps from index 6 to 0 and from index 15 to 0. Indices 7 to 14 read as 0x00, and writes to them are discarded.
- R5: The control register sits at index 15, read through 0x0F and written through 0x8F. Its bit 6 is write protect.
- R6: While write protect is 1, writes to indices 0 to 6 leave those registers unchanged. Writes to the control register are still taken, so writing 0x00 there clears protection.
- R7: Each applied second strobe adds one to BCD seconds. 0x59 wraps to 0x00 and carries into minutes.
- R8: Minutes likewise wrap from 0x59 to 0x00 and carry into hours.
- R9: With hours bit 6 at 0 (24-hour form), hours bits 5:0 count BCD 0x00 to 0x23 and then wrap to 0x00.
- R10: With hours bit 6 at 1 (12-hour form), bits 4:0 hold BCD 1 to 12 and bit 5 is PM. The count goes from 12 to 01 with PM kept, and from 11 to 12 with PM inverted.
- R11: A strobe arriving while chip enable is high is held pending and applied once, right after the frame ends. Any number of strobes within one frame apply as a single step. Reads inside the frame see the values from before the strobe.
- R12: Weekday, day of month, month and year are never changed by strobes, including when hours wrap.
- R13: After reset, every register reads 0x00 and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_ce | input | 1 | Chip enable, active high |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| spi_miso | output | 1 | Serial data to the master |

## Verification
Assertions check three properties on every cycle: write protect freezes the time registers, the time stays frozen inside a frame apart from explicit writes, and the pending strobe clears once the frame has closed. They also check seconds wrapping at 59, the PM flip at the 11-to-12 step, and pointer wrap at the control index. Only the bench scenarios can show the parts that need full SPI traffic. These are the byte order of bursts, the bit order on the wire, the values seen at MISO, the sweeps over every hour value in both hour forms with a carry from 59:59, and the single-step collapse of several strobes within one frame.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   // Packed BCD increment of one byte without range wrap.
   function automatic byte_t bcd_inc(input byte_t v);
      byte_t r;
      if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
      else                r = {v[7:4], v[3:0] + 4'h1};
      return r;
   endfunction

   // Increment with wrap at lim; bit 8 of the result is the carry out.
   function automatic logic [BYTE_W:0] bcd_wrap_inc(input byte_t v, input byte_t lim);
      logic [BYTE_W:0] r;
      if (v == lim) r = {1'b1, 8'h00};
      else          r = {1'b0, bcd_inc(v)};
      return r;
   endfunction

endpackage

// File: rtl/rtc_pin_sync.sv
module rtc_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("rtc_pin_sync: STAGES must be at least 2");
   end

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[gi] <= 1'b0;
            else        chain_q[gi] <= chain_q[gi-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl  = chain_q[STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

endmodule

// File: rtl/rtc_spi_shift.sv
module rtc_spi_shift
   import rtc_spi_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ce_lvl,
   input  logic  ce_rise,
   input  logic  sck_fall,
   input  logic  mosi_lvl,
   input  logic  load_en,
   input  byte_t load_val,
   output logic  miso,
   output logic  byte_vld,
   output logic  byte_first,
   output byte_t byte_val
);
   localparam int unsigned CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0] cnt_q;
   byte_t            rx_q;
   byte_t            tx_q;
   logic             first_q;
   byte_t            rx_nx;

   assign rx_nx = {rx_q[BYTE_W-2:0], mosi_lvl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         rx_q       <= '0;
         tx_q       <= '0;
         first_q    <= 1'b0;
         byte_vld   <= 1'b0;
         byte_first <= 1'b0;
         byte_val   <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (ce_rise) begin
            cnt_q   <= '0;
            tx_q    <= '0;
            first_q <= 1'b1;
         end else if (ce_lvl && sck_fall) begin
            rx_q  <= rx_nx;
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
               byte_vld   <= 1'b1;
               byte_first <= first_q;
               byte_val   <= rx_nx;
               first_q    <= 1'b0;
            end
         end else if (load_en) begin
            tx_q <= load_val;
         end
      end
   end

   assign miso = tx_q[BYTE_W-1] & ce_lvl;

   // R1: a new frame always restarts the bit counter
   a_r1_cnt_restart : assert property (@(posedge clk) disable iff (!rst_n)
      ce_rise |=> (cnt_q == '0));
   // R1: a completed byte is reported for exactly one cycle
   a_r1_vld_single : assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
   import rtc_spi_pkg::*;
#(
   parameter int unsigned N_TIME   = 7,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned CTRL_IDX = 15,
   parameter int unsigned WP_BIT   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  byte_t            wr_val,
   input  logic [IDX_W-1:0] rd_idx,
   output byte_t            rd_val
);
   localparam int unsigned SEC_I  = 0;
   localparam int unsigned MIN_I  = 1;
   localparam int unsigned HR_I   = 2;
   localparam int unsigned HOLD_W = (N_TIME - 3) * BYTE_W;

   if (N_TIME < 4 || N_TIME > CTRL_IDX || CTRL_IDX >= (1 << IDX_W) || WP_BIT >= BYTE_W)
   begin : g_bad_cfg
      $error("rtc_time_regs: inconsistent register map parameters");
   end

   byte_t             tr_q [N_TIME];
   byte_t             ctrl_q;
   logic              pend_q;
   logic              apply;
   logic              wp;
   logic [BYTE_W:0]   sec_step;
   logic [BYTE_W:0]   min_step;
   byte_t             hr_nx;
   byte_t             hr_cur;
   byte_t             hr_inc;
   logic [N_TIME*BYTE_W-1:0] flat;
   logic [HOLD_W-1:0]        hold_flat;

   assign apply = (pend_q | tick) & ~frame;
   assign wp    = ctrl_q[WP_BIT];

   always_comb begin
      sec_step = bcd_wrap_inc(tr_q[SEC_I], 8'h59);
      min_step = bcd_wrap_inc(tr_q[MIN_I], 8'h59);
      hr_cur   = tr_q[HR_I];
      hr_nx    = hr_cur;
      if (hr_cur[6]) begin
         hr_inc = bcd_inc({3'b000, hr_cur[4:0]});
         if (hr_cur[4:0] == 5'h12)      hr_nx = {hr_cur[7:5], 5'h01};
         else if (hr_cur[4:0] == 5'h11) hr_nx = {hr_cur[7:6], ~hr_cur[5], 5'h12};
         else                           hr_nx = {hr_cur[7:5], hr_inc[4:0]};
      end else begin
         hr_inc = bcd_inc({2'b00, hr_cur[5:0]});
         if (hr_cur[5:0] == 6'h23) hr_nx = {hr_cur[7:6], 6'h00};
         else                      hr_nx = {hr_cur[7:6], hr_inc[5:0]};
      end
   end

   for (genvar gi = 0; gi < N_TIME; gi++) begin : g_treg
      logic wr_hit;
      logic adv;
      byte_t adv_val;
      assign wr_hit = wr_en && (wr_idx == IDX_W'(gi)) && !wp;
      if (gi == SEC_I) begin : g_sec
         assign adv     = apply;
         assign adv_val = sec_step[BYTE_W-1:0];
      end else if (gi == MIN_I) begin : g_min
         assign adv     = apply & sec_step[BYTE_W];
         assign adv_val = min_step[BYTE_W-1:0];
      end else if (gi == HR_I) begin : g_hr
         assign adv     = apply & sec_step[BYTE_W] & min_step[BYTE_W];
         assign adv_val = hr_nx;
      end else begin : g_hold
         assign adv     = 1'b0;
         assign adv_val = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      tr_q[gi] <= '0;
         else if (wr_hit) tr_q[gi] <= wr_val;
         else if (adv)    tr_q[gi] <= adv_val;
      end
      assign flat[gi*BYTE_W +: BYTE_W] = tr_q[gi];
   end

   assign hold_flat = flat[N_TIME*BYTE_W-1 : 3*BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pend_q <= 1'b0;
      end else begin
         if (wr_en && wr_idx == IDX_W'(CTRL_IDX)) ctrl_q <= wr_val;
         if (frame && tick) pend_q <= 1'b1;
         else if (!frame)   pend_q <= 1'b0;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int k = 0; k < N_TIME; k++) begin
         if (rd_idx == IDX_W'(k)) rd_val = tr_q[k];
      end
      if (rd_idx == IDX_W'(CTRL_IDX)) rd_val = ctrl_q;
   end

   // R6: protected writes leave every time register untouched
   a_r6_wp_freeze : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wp && wr_idx != IDX_W'(CTRL_IDX) && !apply) |=> $stable(flat));
   // R11: without a write, the time does not move while a frame is open
   a_r11_frame_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (frame && !wr_en) |=> $stable(flat));
   // R11: a pending strobe is consumed once the frame has closed
   a_r11_pend_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !frame) |=> !pend_q);
   // R7: seconds wrap from 59 to 00
   a_r7_sec_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !wr_en && tr_q[SEC_I] == 8'h59) |=> (tr_q[SEC_I] == 8'h00));
   // R10: the 11-to-12 step in 12-hour form flips PM
   a_r10_pm_flip : assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !wr_en && tr_q[SEC_I] == 8'h59 && tr_q[MIN_I] == 8'h59 &&
       tr_q[HR_I][6] && tr_q[HR_I][4:0] == 5'h11) |=> (tr_q[HR_I][5] != $past(tr_q[HR_I][5])));
   // R12: calendar registers change only by writes
   a_r12_cal_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(hold_flat));

endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
   import rtc_spi_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned N_TIME      = 7,
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned CTRL_IDX    = 15,
   parameter int unsigned WP_BIT      = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_ce,
   input  logic spi_sck,
   input  logic spi_mosi,
   input  logic sec_tick,
   output logic spi_miso
);
   logic ce_lvl, ce_rise, ce_fall;
   logic sck_lvl, sck_rise, sck_fall;
   logic mosi_lvl, mosi_rise, mosi_fall;
   logic byte_vld, byte_first;
   byte_t byte_val;
   byte_t rd_val;
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_nx;
   logic [IDX_W-1:0] rd_idx;
   logic             wr_mode_q;
   logic             wr_en;

   rtc_pin_sync #(.STAGES(SYNC_STAGES)) u_ce_sync (
      .clk(clk), .rst_n(rst_n), .din(spi_ce),
      .lvl(ce_lvl), .rise(ce_rise), .fall(ce_fall));
   rtc_pin_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .din(spi_sck),
      .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall));
   rtc_pin_sync #(.STAGES(SYNC_STAGES)) u_mosi_sync (
      .clk(clk), .rst_n(rst_n), .din(spi_mosi),
      .lvl(mosi_lvl), .rise(mosi_rise), .fall(mosi_fall));

   rtc_spi_shift u_shift (
      .clk(clk), .rst_n(rst_n),
      .ce_lvl(ce_lvl), .ce_rise(ce_rise), .sck_fall(sck_fall), .mosi_lvl(mosi_lvl),
      .load_en(byte_vld), .load_val(rd_val),
      .miso(spi_miso), .byte_vld(byte_vld), .byte_first(byte_first), .byte_val(byte_val));

   assign ptr_nx = (ptr_q == IDX_W'(N_TIME - 1) || ptr_q == IDX_W'(CTRL_IDX))
                   ? '0 : ptr_q + 1'b1;
   assign rd_idx = byte_first ? byte_val[IDX_W-1:0] : ptr_nx;
   assign wr_en  = byte_vld & ~byte_first & wr_mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         wr_mode_q <= 1'b0;
      end else if (byte_vld) begin
         if (byte_first) begin
            ptr_q     <= byte_val[IDX_W-1:0];
            wr_mode_q <= byte_val[BYTE_W-1];
         end else begin
            ptr_q <= ptr_nx;
         end
      end
   end

   rtc_time_regs #(
      .N_TIME(N_TIME), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX), .WP_BIT(WP_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .frame(ce_lvl), .tick(sec_tick),
      .wr_en(wr_en), .wr_idx(ptr_q), .wr_val(byte_val),
      .rd_idx(rd_idx), .rd_val(rd_val));

   // R4: pointer leaves the control index for index 0
   a_r4_ctrl_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_first && ptr_q == IDX_W'(CTRL_IDX)) |=> (ptr_q == '0));
   // R4: pointer leaves the last time index for index 0
   a_r4_time_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_first && ptr_q == IDX_W'(N_TIME - 1)) |=> (ptr_q == '0));

endmodule

// File: tb/rtc_spi_regs_tb.sv
module rtc_spi_regs_tb_top;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_ce = 1'b0, spi_sck = 1'b0, spi_mosi = 1'b0, sec_tick = 1'b0;
   logic spi_miso;
   int   checks = 0;
   int   errors = 0;
   logic [7:0] rb [8];

   always #4 clk = ~clk;

   rtc_spi_regs dut_i (
      .clk(clk), .rst_n(rst_n), .spi_ce(spi_ce), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .sec_tick(sec_tick), .spi_miso(spi_miso));

   function automatic logic [7:0] to_bcd(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         spi_sck = 1'b1; spi_mosi = tx[i];
         wait_clk(HALF);
         rx[i] = spi_miso;
         spi_sck = 1'b0;
         wait_clk(HALF);
      end
   endtask

   task automatic open_frame(); spi_ce = 1'b1; wait_clk(HALF); endtask
   task automatic close_frame(); spi_ce = 1'b0; wait_clk(HALF); endtask

   task automatic wr3(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                      input logic [7:0] d2, input int n);
      logic [7:0] dummy;
      open_frame();
      xfer(a, dummy);
      if (n > 0) xfer(d0, dummy);
      if (n > 1) xfer(d1, dummy);
      if (n > 2) xfer(d2, dummy);
      close_frame();
   endtask

   task automatic rd(input logic [7:0] a, input int n);
      logic [7:0] v;
      open_frame();
      xfer(a, v);
      for (int i = 0; i < n; i++) begin xfer(8'h00, v); rb[i] = v; end
      close_frame();
   endtask

   task automatic tick();
      sec_tick = 1'b1; wait_clk(1); sec_tick = 1'b0; wait_clk(4);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_clk(5);
      check("R13 miso in reset", {7'd0, spi_miso}, 8'h00);
      rst_n = 1'b1;
      wait_clk(5);
      rd(8'h00, 7);
      for (int i = 0; i < 7; i++) check("R13 reset value", rb[i], 8'h00);
      rd(8'h0F, 1);
      check("R13 reset ctrl", rb[0], 8'h00);

      // R3 / R2 / R1: full burst write then burst read
      open_frame();
      begin
         logic [7:0] d;
         xfer(8'h80, d);
         xfer(8'h45, d); xfer(8'h32, d); xfer(8'h17, d); xfer(8'h03, d);
         xfer(8'h28, d); xfer(8'h11, d); xfer(8'h99, d);
      end
      close_frame();
      rd(8'h00, 7);
      check("R2 sec",   rb[0], 8'h45);
      check("R2 min",   rb[1], 8'h32);
      check("R3 hour",  rb[2], 8'h17);
      check("R3 wday",  rb[3], 8'h03);
      check("R1 date",  rb[4], 8'h28);
      check("R1 month", rb[5], 8'h11);
      check("R3 year",  rb[6], 8'h99);

      // R4: wrap 6 -> 0 on write and 15 -> 0 on read, hole reads zero
      wr3(8'h86, 8'h25, 8'h33, 8'h00, 2);
      rd(8'h06, 2);
      check("R4 year via wrap", rb[0], 8'h25);
      check("R4 wrap to sec", rb[1], 8'h33);
      wr3(8'h88, 8'h77, 8'h00, 8'h00, 1);
      rd(8'h07, 2);
      check("R4 hole reads zero", rb[0], 8'h00);
      check("R4 hole neighbour", rb[1], 8'h00);
      rd(8'h0F, 2);
      check("R5 ctrl read", rb[0], 8'h00);
      check("R4 ctrl wraps to sec", rb[1], 8'h33);

      // R5 / R6: write protect
      wr3(8'h8F, 8'h40, 8'h00, 8'h00, 1);
      rd(8'h0F, 1);
      check("R5 ctrl holds wp", rb[0], 8'h40);
      wr3(8'h80, 8'h11, 8'h22, 8'h05, 3);
      rd(8'h00, 3);
      check("R6 sec protected",  rb[0], 8'h33);
      check("R6 min protected",  rb[1], 8'h32);
      check("R6 hour protected", rb[2], 8'h17);
      wr3(8'h8F, 8'h00, 8'h00, 8'h00, 1);
      wr3(8'h80, 8'h11, 8'h22, 8'h05, 3);
      rd(8'h00, 1);
      check("R6 unprotected write", rb[0], 8'h11);

      // R7 / R8: exhaustive seconds sweep with minute carry
      wr3(8'h80, 8'h00, 8'h00, 8'h05, 3);
      for (int i = 1; i <= 61; i++) begin
         tick();
         rd(8'h00, 2);
         check("R7 seconds step", rb[0], to_bcd(i % 60));
         check("R8 minutes carry", rb[1], to_bcd(i / 60));
      end

      // R9 / R8: every 24-hour value with a carry from 59:59
      for (int h = 0; h < 24; h++) begin
         wr3(8'h80, 8'h59, 8'h59, to_bcd(h), 3);
         tick();
         rd(8'h00, 3);
         check("R8 min wrap", rb[1], 8'h00);
         check("R9 hour 24h", rb[2], to_bcd((h + 1) % 24));
      end

      // R10: every 12-hour value in both halves of the day
      for (int pm = 0; pm < 2; pm++) begin
         for (int h = 1; h <= 12; h++) begin
            int nh;
            int npm;
            nh  = (h == 12) ? 1 : h + 1;
            npm = (h == 11) ? 1 - pm : pm;
            wr3(8'h80, 8'h59, 8'h59, 8'h40 | 8'(pm * 32) | to_bcd(h), 3);
            tick();
            rd(8'h02, 1);
            check("R10 hour 12h", rb[0], 8'h40 | 8'(npm * 32) | to_bcd(nh));
         end
      end

      // R12: calendar untouched by a full day wrap
      open_frame();
      begin
         logic [7:0] d;
         xfer(8'h80, d);
         xfer(8'h59, d); xfer(8'h59, d); xfer(8'h23, d); xfer(8'h06, d);
         xfer(8'h31, d); xfer(8'h12, d); xfer(8'h49, d);
      end
      close_frame();
      tick();
      rd(8'h00, 7);
      check("R12 hour wrapped", rb[2], 8'h00);
      check("R12 wday held",  rb[3], 8'h06);
      check("R12 date held",  rb[4], 8'h31);
      check("R12 month held", rb[5], 8'h12);
      check("R12 year held",  rb[6], 8'h49);

      // R11: strobes inside a frame are deferred and merged
      wr3(8'h80, 8'h10, 8'h00, 8'h00, 1);
      open_frame();
      begin
         logic [7:0] d;
         xfer(8'h00, d);
         tick(); tick(); tick();
         xfer(8'h00, d);
         check("R11 snapshot in frame", d, 8'h10);
      end
      close_frame();
      rd(8'h00, 1);
      check("R11 single deferred step", rb[0], 8'h11);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule